// File: doc/BRIEF.md
# Interrupt Register Bank Controller

This block keeps a stack of hardware register banks. The CPU uses it to save and restore its context quickly around interrupts. When an interrupt that may use a bank is accepted, the controller copies the nineteen context words into the next free bank in a single cycle. The nineteen words are R0 through R14, GBR, MACH, MACL and PR. It then advances a bank number counter.

A restore-bank instruction works in the other direction. The controller steps the counter back and places the saved words on a restore bus, marked by a one-cycle valid pulse. The CPU register file takes the words from that bus.

Two misuse cases are detected and neither one corrupts state. An interrupt that arrives with every bank full is an overflow, and a restore with no bank in use is an underflow. The controller reports the error as a one-cycle pulse with a type code, and the exception logic around it acts on that pulse. An input from the interrupt controller masks overflow. With overflow masked, an interrupt that arrives while all banks are full is accepted without saving anything and without raising an error.

Top module: `irbank_ctrl`

## Requirements
- R1: After reset, `bank_num` is 0, and `rst_valid` and `err_pulse` are low with `err_type` equal to 2'b00.
- R2: When `save_req` is high and `bank_num` is below NBANKS, the bank indexed by `bank_num` stores `ctx_in`, and `bank_num` increases by one at the next edge.
- R3: When `save_req` is high, `bank_num` equals NBANKS and `ovf_unmask` is high, the next cycle shows `err_pulse` high with `err_type` 2'b01. `bank_num` stays at NBANKS and no bank is written.
- R4: When `save_req` is high, `bank_num` equals NBANKS and `ovf_unmask` is low, no error is raised, `bank_num` stays at NBANKS and no bank is written.
- R5: When `restore_req` is high without `save_req` and `bank_num` is nonzero, `bank_num` drops by one at the next edge. In the same cycle `rst_ctx` carries the words of bank `bank_num-1` and `rst_valid` is high for that cycle.
- R6: When `restore_req` is high without `save_req` and `bank_num` is 0, the next cycle shows `err_pulse` high with `err_type` 2'b10. `rst_valid` stays low, `rst_ctx` keeps its value and `bank_num` stays at 0.
- R7: In a cycle with neither request, `bank_num` and `rst_ctx` hold their values. The following cycle shows `rst_valid` and `err_pulse` low and `err_type` equal to 2'b00.
- R8: When `save_req` and `restore_req` are high together, the save (or the overflow handling) takes effect and the restore is ignored.
- R9: Banks are restored in last-saved, first-restored order. Word k of `ctx_in` and of `rst_ctx` occupies bits [32k+31:32k] with the default word width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| save_req | input | 1 | Accepted interrupt with bank use allowed |
| ovf_unmask | input | 1 | High lets a full-stack save raise an overflow error |
| ctx_in | input | NREGS*WORD_W | Context words to save |
| restore_req | input | 1 | Restore-bank instruction executes |
| rst_ctx | output | NREGS*WORD_W | Restored context words |
| rst_valid | output | 1 | One-cycle pulse marking valid `rst_ctx` |
| bank_num | output | $clog2(NBANKS+1) | Number of banks in use |
| err_pulse | output | 1 | One-cycle bank error pulse |
| err_type | output | 2 | 01 overflow, 10 underflow, 00 otherwise |

## Verification
The hardest case to reach is overflow, because it needs fifteen more saves than restores in a row. Uniform random operations would almost never get there. The stimulus therefore runs directed fills to the top of the stack. It then runs random phases that favour saves or restores, so the stack keeps reaching both the full and the empty end. A bench model of the stack compares every restored word against the expected value. This shows that an overflow or a masked full-stack save leaves the stored banks untouched.

// File: rtl/irbank_ctrl.sv
module irbank_ctrl #(
  parameter int NBANKS = 15,
  parameter int WORD_W = 32,
  parameter int NREGS  = 19,
  localparam int CTX_W = NREGS * WORD_W,
  localparam int CW    = $clog2(NBANKS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             save_req,
  input  logic             ovf_unmask,
  input  logic [CTX_W-1:0] ctx_in,
  input  logic             restore_req,
  output logic [CTX_W-1:0] rst_ctx,
  output logic             rst_valid,
  output logic [CW-1:0]    bank_num,
  output logic             err_pulse,
  output logic [1:0]       err_type
);
  localparam logic [CW-1:0] FULL = CW'(NBANKS);

  logic [CTX_W-1:0] bank_q [NBANKS];
  logic [CW-1:0]    cnt_q;
  logic [1:0]       etype_q;

  wire full     = (cnt_q == FULL);
  wire empty    = (cnt_q == '0);
  wire do_save  = save_req && !full;
  wire do_ovf   = save_req && full && ovf_unmask;
  wire rest_ok  = restore_req && !save_req;
  wire do_rest  = rest_ok && !empty;
  wire do_udf   = rest_ok && empty;
  wire [CW-1:0] rd_idx = cnt_q - 1'b1;

  always_ff @(posedge clk) begin
    if (do_save) bank_q[cnt_q] <= ctx_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      rst_ctx   <= '0;
      rst_valid <= 1'b0;
      etype_q   <= 2'b00;
    end else begin
      rst_valid <= do_rest;
      etype_q   <= do_ovf ? 2'b01 : (do_udf ? 2'b10 : 2'b00);
      if (do_save) cnt_q <= cnt_q + 1'b1;
      else if (do_rest) begin
        cnt_q   <= rd_idx;
        rst_ctx <= bank_q[rd_idx];
      end
    end
  end

  assign bank_num  = cnt_q;
  assign err_type  = etype_q;
  assign err_pulse = |etype_q;

  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bank_num <= FULL);
  assert_save_inc_R2: assert property (@(posedge clk) disable iff (!rst_n)
    save_req && bank_num != FULL |=> bank_num == $past(bank_num) + 1'b1);
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    save_req && bank_num == FULL && ovf_unmask |=> bank_num == FULL && err_pulse && err_type == 2'b01);
  assert_masked_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
    save_req && bank_num == FULL && !ovf_unmask |=> bank_num == FULL && !err_pulse);
  assert_restore_R5: assert property (@(posedge clk) disable iff (!rst_n)
    restore_req && !save_req && bank_num != '0 |=> rst_valid && bank_num == $past(bank_num) - 1'b1);
  assert_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    restore_req && !save_req && bank_num == '0 |=> !rst_valid && err_type == 2'b10 && bank_num == '0 && $stable(rst_ctx));
  assert_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !save_req && !restore_req |=> $stable(bank_num) && $stable(rst_ctx) && !rst_valid && !err_pulse);
  assert_save_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    save_req && restore_req |=> !rst_valid && err_type != 2'b10);
endmodule

// File: tb/irbank_ctrl_bench.sv
module irbank_ctrl_bench;
  localparam int NB = 15;
  localparam int CTX_W = 19 * 32;
  localparam int CW = $clog2(NB + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic save_req = 0, ovf_unmask = 0, restore_req = 0;
  logic [CTX_W-1:0] ctx_in = '0;
  logic [CTX_W-1:0] rst_ctx;
  logic rst_valid, err_pulse;
  logic [CW-1:0] bank_num;
  logic [1:0] err_type;

  int tests = 0, fails = 0;
  logic [CTX_W-1:0] mbank [NB];
  int mcnt = 0;
  logic [CTX_W-1:0] mrst = '0;
  logic done = 0;

  always #2 clk = ~clk;

  irbank_ctrl u_irbank_ctrl (.clk, .rst_n, .save_req, .ovf_unmask, .ctx_in,
    .restore_req, .rst_ctx, .rst_valid, .bank_num, .err_pulse, .err_type);

  task automatic chk(input bit ok, input string tag, input logic [CTX_W-1:0] act, input logic [CTX_W-1:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [CTX_W-1:0] rnd_ctx();
    logic [CTX_W-1:0] v;
    for (int k = 0; k < 19; k++) v[k*32 +: 32] = $urandom;
    return v;
  endfunction

  function automatic logic [1:0] exp_err(input bit s, input bit r, input bit u, input int c);
    if (s) return (c == NB && u) ? 2'b01 : 2'b00;
    if (r && c == 0) return 2'b10;
    return 2'b00;
  endfunction

  task automatic step(input bit s, input bit r, input bit u);
    logic [1:0] ee;
    bit ev;
    @(negedge clk);
    save_req = s; restore_req = r; ovf_unmask = u; ctx_in = rnd_ctx();
    ee = exp_err(s, r, u, mcnt);
    ev = 0;
    if (s) begin
      if (mcnt < NB) begin mbank[mcnt] = ctx_in; mcnt++; end
    end else if (r && mcnt > 0) begin
      mcnt--; mrst = mbank[mcnt]; ev = 1;
    end
    @(posedge clk); #1;
    chk(bank_num == CW'(mcnt), s ? (mcnt == NB ? "R3/R4 count" : "R2 count") : (r ? "R5/R6 count" : "R7 count"), CTX_W'(bank_num), CTX_W'(mcnt));
    chk(err_type == ee && err_pulse == (ee != 0), ee == 2'b01 ? "R3 err" : (ee == 2'b10 ? "R6 err" : "R4/R7/R8 no err"), CTX_W'(err_type), CTX_W'(ee));
    chk(rst_valid == ev, s && r ? "R8 valid" : "R5 valid", CTX_W'(rst_valid), CTX_W'(ev));
    chk(rst_ctx == mrst, "R5/R9 restored data", rst_ctx, mrst);
  endtask

  initial begin
    void'($urandom(32'd2024));
    #7;
    chk(bank_num == 0 && !rst_valid && !err_pulse && err_type == 0, "R1 reset", CTX_W'(bank_num), '0);
    rst_n = 1'b1;
    step(0, 1, 1);                                 // R6 underflow at start
    step(0, 0, 0);                                 // R7 idle clears pulse
    for (int i = 0; i < NB; i++) step(1, 0, 1);    // R2 fill
    step(1, 0, 1);                                 // R3 overflow
    step(1, 0, 0);                                 // R4 masked full
    step(1, 1, 1);                                 // R8 + R3
    step(0, 0, 1);
    for (int i = 0; i < NB; i++) step(0, 1, 0);    // R5 R9 LIFO drain
    step(0, 1, 0);                                 // R6
    step(1, 1, 0);                                 // R8 save wins
    step(0, 1, 0);
    for (int ph = 0; ph < 40; ph++) begin
      int bias = (ph % 2 == 0) ? 80 : 20;
      for (int j = 0; j < 40; j++) begin
        int x = $urandom_range(99);
        int y = $urandom_range(99);
        step(x < bias, y < (100 - bias), $urandom_range(1));
      end
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (100000) @(posedge clk); tests++; fails++; $display("FAIL watchdog expired"); end
    join_any
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule